// File: doc/BRIEF.md
# Adaptive Exponential Neuron Datapath

This block advances the state of one adaptive exponential integrate-and-fire neuron by one forward-Euler step on every clock edge at which `run` is high. It holds two signed fixed-point registers with 4 integer and 8 fractional bits: the membrane level V and the adaptation current w. Each step moves V by a leak toward a fixed rest level, adds a soft exponential pull as V nears the threshold, and subtracts w. It then adds the bias drive and scales the sum by the capacitance. At the same time w relaxes toward a subthreshold coupling term at a rate set by the adaptation time constant. When a step would carry V to or past the threshold, V is loaded with the reset level instead. w then receives the spike increment, and `spike` is high for the following cycle.

The eight model constants arrive as parallel 8-bit inputs and are expected to stay stable while the neuron runs. The three level-type constants (reset level, threshold and drive) are signed values carried with an offset of 128. The other five are unsigned. `run` and `show_w` are plain level controls, and the block has no data stream, so there is no handshake at its edge. A 6-bit observation bus shows the top bits of V or of w.

Top module: `adex_neuron`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, V equals the rest level of −70 (−1120 LSB, debug code 0x2E), w is 0 and spike is low. Reset is asynchronous.
- R2: For the reset level, threshold and drive inputs, a code k means a level of (k − 128)·16 LSB. The spike increment b adds b·16 LSB. The other inputs are plain unsigned numbers.
- R3: When the step result for V is greater than or equal to the threshold, V takes the reset level and spike is high in the next cycle only. Spike is otherwise low.
- R4: On a spiking step, w becomes the saturated sum of its stepped value and b·16. With a = 0 and b = 0, w stays 0.
- R5: While run is low, V and w hold their values and spike stays low.
- R6: dbg carries bits 11:6 of V when show_w is 0 and bits 11:6 of w when show_w is 1.
- R7: V and w saturate at −2048 and +2047 LSB and never wrap.
- R8: With drive 200, capacitance 200, DeltaT 2, threshold 78 and a = b = 0, a spike appears within 1000 enabled cycles after reset.
- R9: With a > 0 and V held above rest, w climbs to a positive value. The step adds ((ad − w) >>> msb(TauW)) to w, where ad = ((V − rest)·a) >>> 4.
- R10: The V step is (rest − V + X − w + I) >>> msb(C), where msb(x) is the index of the highest set bit (0 for x = 0). X = (DeltaT·E) >> 4. E is a 1/256-unit approximation of 2^u taken as (1 + frac)·2^floor. u = ((V − VT)·16) >>> msb(DeltaT) in 1/256 units, clamped to [−8, +3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Advance one step per cycle while high |
| show_w | input | 1 | Debug select: 0 shows V, 1 shows w |
| prm_sharp | input | 8 | Exponential sharpness DeltaT, unsigned |
| prm_tau | input | 8 | Adaptation time constant, unsigned |
| prm_gain | input | 8 | Subthreshold adaptation a, unsigned |
| prm_kick | input | 8 | Spike increment b, unsigned |
| prm_vrst | input | 8 | Reset level, offset 128 |
| prm_vthr | input | 8 | Threshold, offset 128 |
| prm_drive | input | 8 | Bias drive, offset 128 |
| prm_cap | input | 8 | Capacitance, unsigned |
| spike | output | 1 | One-cycle firing flag |
| dbg | output | 6 | Top bits of V or w |

## Verification
One single step from rest is made with DeltaT = 0 and again with DeltaT = 255 at a threshold of 0. The two results differ only through the exponential term, which checks its approximation and clamping by value. A strong positive drive makes the neuron fire repeatedly. This separates the reset-level load and the one-cycle pulse from the step arithmetic. Two increments, one moderate and one that overflows, show b being added and saturated. A strongly negative drive pins V at the lower rail. A high threshold with a > 0 shows the subthreshold coupling raising w, and a frozen interval shows that nothing moves while run is low.

// File: rtl/adex_pkg.sv
package adex_pkg;

  localparam int STATE_W  = 12;   // Q4.8 state width
  localparam int FRAC_W   = 8;
  localparam int PRM_W    = 8;
  localparam int LVL_SH   = 4;    // parameter code to state LSB scaling
  localparam int GAIN_SH  = 4;    // scaling of the a * (V - rest) product
  localparam int EXP_TOP  = 3;    // upper clamp of the exponent, in whole units
  localparam int DBG_W    = 6;

  // order of the packed groups handed to the decoder
  localparam int LVL_RST = 0;
  localparam int LVL_THR = 1;
  localparam int LVL_DRV = 2;
  localparam int DIV_DT  = 0;
  localparam int DIV_TAU = 1;
  localparam int DIV_CAP = 2;

  typedef enum logic {SHOW_V = 1'b0, SHOW_W = 1'b1} dbg_sel_e;

  function automatic int sat_to(input int x, input int width);
    int hi;
    int lo;
    hi = (1 <<< (width - 1)) - 1;
    lo = -(1 <<< (width - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

endpackage

// File: rtl/adex_param_decode.sv
module adex_param_decode
  import adex_pkg::*;
#(
  parameter int PW  = PRM_W,
  parameter int DW  = STATE_W,
  parameter int LSH = LVL_SH,
  parameter int SHW = $clog2(PW)
) (
  input  logic [2:0][PW-1:0]  lvl_raw,
  input  logic [2:0][PW-1:0]  div_raw,
  input  logic [PW-1:0]       kick_raw,
  output logic [2:0][DW-1:0]  lvl_c,
  output logic [2:0][SHW-1:0] div_sh,
  output logic [DW:0]         kick_c
);

  localparam int OFFSET = 1 << (PW - 1);

  function automatic logic [SHW-1:0] top_bit(input logic [PW-1:0] x);
    logic [SHW-1:0] idx;
    idx = '0;
    for (int i = 0; i < PW; i++)
      if (x[i]) idx = SHW'(i);
    return idx;
  endfunction

  function automatic logic [DW-1:0] centre(input logic [PW-1:0] raw);
    int c;
    c = (int'(raw) - OFFSET) <<< LSH;
    return DW'(c);
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    assign lvl_c[g] = centre(lvl_raw[g]);
  end

  for (genvar g = 0; g < 3; g++) begin : g_div
    assign div_sh[g] = top_bit(div_raw[g]);
  end

  assign kick_c = (DW + 1)'(kick_raw) << LSH;

endmodule

// File: rtl/adex_exp2.sv
module adex_exp2
  import adex_pkg::*;
#(
  parameter int DW  = STATE_W,
  parameter int FW  = FRAC_W,
  parameter int LSH = LVL_SH,
  parameter int SHW = 3,
  parameter int HI  = EXP_TOP,
  parameter int EW  = FW + 1 + HI
) (
  input  logic signed [DW-1:0] v,
  input  logic signed [DW-1:0] vthr,
  input  logic [SHW-1:0]       sh,
  output logic [EW-1:0]        e_q
);

  localparam int U_LO = -(FW <<< FW);
  localparam int U_HI = HI <<< FW;

  int          u;
  int          n;
  logic [EW-1:0] mant;

  always_comb begin
    u = ((int'(v) - int'(vthr)) <<< (FW - LSH)) >>> sh;
    if (u < U_LO) u = U_LO;
    if (u > U_HI) u = U_HI;
    n    = u >>> FW;
    mant = EW'({1'b1, u[FW-1:0]});
    if (n >= 0) e_q = mant << n;
    else        e_q = mant >> (-n);
  end

endmodule

// File: rtl/adex_drift.sv
module adex_drift
  import adex_pkg::*;
#(
  parameter int DW   = STATE_W,
  parameter int FW   = FRAC_W,
  parameter int PW   = PRM_W,
  parameter int LSH  = LVL_SH,
  parameter int ASH  = GAIN_SH,
  parameter int SHW  = 3,
  parameter int EW   = FW + 1 + EXP_TOP,
  parameter int REST = -1120
) (
  input  logic signed [DW-1:0] v,
  input  logic signed [DW-1:0] w,
  input  logic signed [DW-1:0] drive,
  input  logic [EW-1:0]        e_q,
  input  logic [PW-1:0]        sharp,
  input  logic [PW-1:0]        gain,
  input  logic [SHW-1:0]       sh_cap,
  input  logic [SHW-1:0]       sh_tau,
  output logic signed [DW-1:0] v_step,
  output logic signed [DW-1:0] w_step
);

  int ex;
  int sum_v;
  int ad;
  int v_new;
  int w_new;

  always_comb begin
    ex     = (int'(sharp) * int'(e_q)) >>> (FW - LSH);
    sum_v  = (REST - int'(v)) + ex - int'(w) + int'(drive);
    v_new  = int'(v) + (sum_v >>> sh_cap);
    ad     = ((int'(v) - REST) * int'(gain)) >>> ASH;
    w_new  = int'(w) + ((ad - int'(w)) >>> sh_tau);
    v_step = DW'(sat_to(v_new, DW));
    w_step = DW'(sat_to(w_new, DW));
  end

endmodule

// File: rtl/adex_neuron.sv
module adex_neuron
  import adex_pkg::*;
#(
  parameter int DW        = STATE_W,
  parameter int FW        = FRAC_W,
  parameter int PW        = PRM_W,
  parameter int LSH       = LVL_SH,
  parameter int REST_REAL = -70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             show_w,
  input  logic [PW-1:0]    prm_sharp,
  input  logic [PW-1:0]    prm_tau,
  input  logic [PW-1:0]    prm_gain,
  input  logic [PW-1:0]    prm_kick,
  input  logic [PW-1:0]    prm_vrst,
  input  logic [PW-1:0]    prm_vthr,
  input  logic [PW-1:0]    prm_drive,
  input  logic [PW-1:0]    prm_cap,
  output logic             spike,
  output logic [DBG_W-1:0] dbg
);

  localparam int SHW  = $clog2(PW);
  localparam int EW   = FW + 1 + EXP_TOP;
  localparam int REST = REST_REAL <<< LSH;
  localparam logic signed [DW-1:0] REST_C = DW'(REST);

  logic [2:0][PW-1:0]  lvl_raw;
  logic [2:0][PW-1:0]  div_raw;
  logic [2:0][DW-1:0]  lvl_c;
  logic [2:0][SHW-1:0] div_sh;
  logic [DW:0]         kick_c;
  logic signed [DW-1:0] vrst_c, vthr_c, drive_c;
  logic signed [DW-1:0] v_q, w_q, v_step, w_step, w_bump;
  logic [EW-1:0]        e_q;
  logic                 fire;

  assign lvl_raw = {prm_drive, prm_vthr, prm_vrst};
  assign div_raw = {prm_cap, prm_tau, prm_sharp};

  adex_param_decode #(.PW(PW), .DW(DW), .LSH(LSH), .SHW(SHW)) u_dec (
    .lvl_raw (lvl_raw),
    .div_raw (div_raw),
    .kick_raw(prm_kick),
    .lvl_c   (lvl_c),
    .div_sh  (div_sh),
    .kick_c  (kick_c)
  );

  assign vrst_c  = $signed(lvl_c[LVL_RST]);
  assign vthr_c  = $signed(lvl_c[LVL_THR]);
  assign drive_c = $signed(lvl_c[LVL_DRV]);

  adex_exp2 #(.DW(DW), .FW(FW), .LSH(LSH), .SHW(SHW), .HI(EXP_TOP), .EW(EW)) u_exp (
    .v   (v_q),
    .vthr(vthr_c),
    .sh  (div_sh[DIV_DT]),
    .e_q (e_q)
  );

  adex_drift #(.DW(DW), .FW(FW), .PW(PW), .LSH(LSH), .ASH(GAIN_SH), .SHW(SHW),
               .EW(EW), .REST(REST)) u_drift (
    .v     (v_q),
    .w     (w_q),
    .drive (drive_c),
    .e_q   (e_q),
    .sharp (prm_sharp),
    .gain  (prm_gain),
    .sh_cap(div_sh[DIV_CAP]),
    .sh_tau(div_sh[DIV_TAU]),
    .v_step(v_step),
    .w_step(w_step)
  );

  assign fire   = (v_step >= vthr_c);
  assign w_bump = DW'(sat_to(int'(w_step) + int'(kick_c), DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= REST_C;
      w_q   <= '0;
      spike <= 1'b0;
    end else if (run) begin
      if (fire) begin
        v_q   <= vrst_c;
        w_q   <= w_bump;
        spike <= 1'b1;
      end else begin
        v_q   <= v_step;
        w_q   <= w_step;
        spike <= 1'b0;
      end
    end else begin
      spike <= 1'b0;
    end
  end

  assign dbg = (dbg_sel_e'(show_w) == SHOW_W) ? w_q[DW-1 -: DBG_W] : v_q[DW-1 -: DBG_W];

endmodule

// File: rtl/adex_neuron_chk.sv
module adex_neuron_chk #(
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 spike,
  input logic signed [DW-1:0] v_q,
  input logic signed [DW-1:0] w_q,
  input logic signed [DW-1:0] vrst_c
);

  assert_spike_after_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(run));

  // R3: a firing step leaves V at the reset level seen at that edge
  assert_spike_loads_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> (v_q == $past(vrst_c)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(v_q) && $stable(w_q)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !spike);

endmodule

bind adex_neuron adex_neuron_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run),
  .spike (spike),
  .v_q   (v_q),
  .w_q   (w_q),
  .vrst_c(vrst_c)
);

// File: tb/sim_adex_neuron.sv
module sim_adex_neuron;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       show_w = 1'b0;
  logic [7:0] p_dt = 8'd0, p_tau = 8'd0, p_a = 8'd0, p_b = 8'd0;
  logic [7:0] p_rst = 8'd0, p_thr = 8'd0, p_drv = 8'd0, p_cap = 8'd0;
  logic       spike;
  logic [5:0] dbg;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adex_neuron u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .show_w(show_w),
    .prm_sharp(p_dt), .prm_tau(p_tau), .prm_gain(p_a), .prm_kick(p_b),
    .prm_vrst(p_rst), .prm_vthr(p_thr), .prm_drive(p_drv), .prm_cap(p_cap),
    .spike(spike), .dbg(dbg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic set_prm(input int dt, tau, a, b, rs, th, dr, cap);
    p_dt = 8'(dt); p_tau = 8'(tau); p_a = 8'(a); p_b = 8'(b);
    p_rst = 8'(rs); p_thr = 8'(th); p_drv = 8'(dr); p_cap = 8'(cap);
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0; show_w = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic peek(output int vv, output int ww);
    show_w = 1'b0; #1 vv = int'(dbg);
    show_w = 1'b1; #1 ww = int'(dbg);
    show_w = 1'b0; #1;
  endtask

  // run until the first spike; returns enabled cycle count (-1 if none)
  task automatic until_spike(input int limit, output int cyc);
    cyc = -1;
    run = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (spike) begin cyc = i; break; end
    end
  endtask

  task automatic t_reset_state();
    int vv, ww;
    @(negedge clk);
    peek(vv, ww);
    chk_eq("R1 V at rest during reset (R6 V view)", vv, 8'h2E);
    chk_eq("R1 w zero during reset (R6 w view)", ww, 0);
    chk_eq("R1 spike low during reset", int'(spike), 0);
  endtask

  task automatic t_first_step();
    int vv, ww;
    // R10: strong exponential, threshold 0, no drive, C=16
    do_reset();
    set_prm(255, 1, 0, 0, 0, 128, 128, 16);
    run = 1'b1; @(negedge clk); run = 1'b0;
    peek(vv, ww);
    chk_eq("R10 one step with exponential term", vv, 8'h31);
    chk_eq("R10 no spike below threshold", int'(spike), 0);
    do_reset();
    set_prm(0, 1, 0, 0, 0, 128, 128, 16);
    run = 1'b1; @(negedge clk); run = 1'b0;
    peek(vv, ww);
    chk_eq("R10 one step with DeltaT 0 stays at rest", vv, 8'h2E);
  endtask

  task automatic t_fire();
    int cyc, vv, ww, spikes, dbl, badv;
    bit prev;
    do_reset();
    set_prm(2, 100, 0, 0, 28, 78, 200, 200);
    until_spike(1000, cyc);
    chk(cyc > 0, "R8 spike within 1000 cycles", cyc, 1000);
    peek(vv, ww);
    chk_eq("R3 V at reset level on spike (R2 offset code)", vv, 8'h27);
    chk_eq("R4 w stays zero with a=0 b=0", ww, 0);
    spikes = 0; dbl = 0; badv = 0; prev = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (spike) begin
        spikes++;
        if (prev) dbl++;
        show_w = 1'b0; #1;
        if (dbg != 6'h27) badv++;
      end
      prev = spike;
    end
    run = 1'b0;
    chk(spikes >= 2, "R3 repeated firing", spikes, 2);
    chk_eq("R3 spike lasts one cycle", dbl, 0);
    chk_eq("R3 V reloaded on every spike", badv, 0);
  endtask

  task automatic t_kick();
    int cyc, vv, ww;
    do_reset();
    set_prm(2, 255, 0, 64, 28, 78, 200, 200);
    until_spike(1000, cyc);
    run = 1'b0;
    peek(vv, ww);
    chk_eq("R4 w raised by b*16 on spike", ww, 8'h10);
    do_reset();
    set_prm(2, 255, 0, 255, 28, 78, 200, 200);
    until_spike(1000, cyc);
    run = 1'b0;
    peek(vv, ww);
    chk_eq("R7 w saturates at +2047 on large b", ww, 8'h1F);
  endtask

  task automatic t_hold();
    int v0, w0, vv, ww, moved, spk;
    do_reset();
    set_prm(2, 16, 16, 0, 28, 78, 200, 200);
    run = 1'b1;
    repeat (20) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    peek(v0, w0);
    moved = 0; spk = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (spike) spk++;
      peek(vv, ww);
      if (vv != v0 || ww != w0) moved++;
    end
    chk_eq("R5 state frozen while run low", moved, 0);
    chk_eq("R5 no spike while run low", spk, 0);
    chk(v0 != 8'h2E, "R5 V had advanced before freeze", v0, 8'h2E);
  endtask

  task automatic t_floor();
    int vv, ww, spk;
    do_reset();
    set_prm(2, 100, 0, 0, 28, 78, 0, 200);
    run = 1'b1; spk = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (spike) spk++;
    end
    run = 1'b0;
    peek(vv, ww);
    chk_eq("R7 V clamps at -2048", vv, 8'h20);
    chk_eq("R3 no spike with negative drive", spk, 0);
  endtask

  task automatic t_adapt();
    int vv, ww, spk;
    do_reset();
    set_prm(2, 16, 16, 0, 28, 255, 200, 200);
    run = 1'b1; spk = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (spike) spk++;
    end
    run = 1'b0;
    peek(vv, ww);
    chk(ww >= 1 && ww <= 31, "R9 w positive with a>0", ww, 9);
    chk_eq("R9 no spike under high threshold", spk, 0);
    do_reset();
    set_prm(2, 16, 0, 0, 28, 255, 200, 200);
    run = 1'b1;
    repeat (300) @(negedge clk);
    run = 1'b0;
    peek(vv, ww);
    chk_eq("R4 w stays zero with a=0", ww, 0);
  endtask

  task automatic t_async_reset();
    int vv, ww;
    do_reset();
    set_prm(2, 255, 0, 64, 28, 78, 200, 200);
    run = 1'b1;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #1;
    peek(vv, ww);
    chk_eq("R1 async reset V", vv, 8'h2E);
    chk_eq("R1 async reset w", ww, 0);
    chk_eq("R1 async reset spike", int'(spike), 0);
    run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset_state();
    do_reset();
    t_first_step();
    t_fire();
    t_kick();
    t_hold();
    t_floor();
    t_adapt();
    t_async_reset();
    finished = 1'b1;
    report();
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
    end
  end

endmodule